// File: doc/BRIEF.md
# Cascadable Successive Approximation Register

This block sequences a successive-approximation analog-to-digital conversion. When a conversion begins it clears its code and sets the most significant bit as the trial bit. The code drives an external DAC and an external comparator answers. On each rising clock edge the bit under test keeps the comparator's answer and the next lower bit becomes the new trial. The decided bits leave one per clock on a serial output, most significant first. An end-of-conversion flag marks the moment when the parallel code is final and the last serial bit is present.

An extension input ends a conversion early, after the bit that is under test when it is seen high. Tying it to a lower code bit shortens the register to fewer bits. A carry output marks the cycle in which the final decision is pending. This lets a second register start exactly when the first one finishes, so two registers can form a longer converter. A parameter chooses between two restart behaviours. An upper stage can leave its idle state on its own after reset. A lower stage waits in a stable idle state for its start.

The comparator is a single digital input. The DAC and all analog behaviour are outside the block.

Top module: `sar_cascadable_reg`

## Requirements
- R1: With FREE_RUN=0, after reset `code_q`, `eoc`, `ser_out` and `carry_out` are all 0, and they stay 0 on every clock while `start` is low.
- R2: At a rising edge where `start` is high and the register is idle or finished, `code_q` becomes a word with only bit WIDTH-1 set, and `eoc` drops to 0.
- R3: At each rising edge during a conversion, the bit under test takes `cmp_in` (1 keeps it, 0 clears it) and the next lower bit is set as the new trial, from the MSB downward. With a comparator that answers 1 when `code_q` is at or below an input level, the final code equals that level.
- R4: With `ext_in` low, `eoc` rises at the WIDTH-th decision edge after the load edge. `eoc` and `code_q` then hold unchanged until the next start is accepted.
- R5: After each decision edge, `ser_out` equals the bit just decided, MSB first. The last bit appears in the same cycle that `eoc` rises.
- R6: `start` is ignored while a conversion is running: the result and the timing of `eoc` do not change.
- R7: With `eoc` fed back to `start`, or with `start` held high, a new conversion loads on the edge after `eoc` rises. With `ext_in` low this gives one fresh result every WIDTH+1 clocks.
- R8: If `ext_in` is high at a decision edge, that edge decides the current bit and ends the conversion, and no lower trial bit is set. With `ext_in` tied to `code_q[k]`, the conversion resolves bits WIDTH-1 down to k in WIDTH-k edges. The bits below k end at 0.
- R9: `carry_out` is high exactly in the cycle before the final decision edge of a conversion. That is the cycle in which the LSB is under test, or `ext_in` is high, while converting. It is low otherwise.
- R10: With FREE_RUN=1, the register loads its first trial on the first edge after reset without `start`. Once finished, it waits in the finished state for `start`.
- R11: A FREE_RUN=1 upper stage and a 4-bit shortened lower stage can be chained. The chain is wired as lower start = upper `carry_out` and upper start = lower `eoc`. It refreshes a 12-bit result every 13 clocks. The lower stage stays idle with a zero code until the upper stage first reaches its final decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, sampled when idle or finished |
| cmp_in | input | 1 | Comparator answer for the current trial code (1 = keep bit) |
| ext_in | input | 1 | Early-end input; high during a decision ends the conversion |
| code_q | output | WIDTH | Trial code to the DAC and, once finished, the parallel result |
| ser_out | output | 1 | Most recently decided bit, MSB first |
| eoc | output | 1 | End of conversion; result valid and serial word complete |
| carry_out | output | 1 | Final decision is pending this cycle; start for a chained stage |

## Verification
A pointer that skips or repeats a position shows up at `code_q` within one clock. A trial bit lands in the wrong place, so the final code for some input level differs from that level, and `eoc` comes early or late against the WIDTH-edge count. A state machine that fails to hold after finishing makes `code_q` or `eoc` move in the cycle after `eoc` rises. A wrong restart rule shows up in the first cycle after reset, or as a changed period between end flags in the chained pair. The serial stream is compared bit by bit against the level's binary digits, so a misrouted decision surfaces at the first wrong bit position.

// File: rtl/sar_pkg.sv
// Shared types of the successive approximation register.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package sar_pkg;

    // Phase of the conversion sequencer.
    typedef enum logic [1:0] {
        SAR_IDLE = 2'd0,
        SAR_BUSY = 2'd1,
        SAR_DONE = 2'd2
    } sar_phase_e;

endpackage

// File: rtl/sar_sequencer.sv
// Conversion sequencer: walks a one-hot pointer from the MSB to the LSB,
// one position per edge, and decides when a conversion starts and ends.
// Assumes: start is a synchronous level; ext_in is only meaningful while busy.
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter bit FREE_RUN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ext_in,
    output logic             load,
    output logic             busy,
    output logic             last,
    output logic             done,
    output logic [WIDTH-1:0] ptr
);

    localparam logic [WIDTH-1:0] MSB_HOT = {1'b1, {(WIDTH-1){1'b0}}};

    sar_phase_e phase_q;

    // Decode the current phase and the start condition.
    always_comb begin
        busy = (phase_q == SAR_BUSY);
        done = (phase_q == SAR_DONE);
        load = ((phase_q == SAR_IDLE) && (start || FREE_RUN)) ||
               ((phase_q == SAR_DONE) && start);
        last = busy && (ptr[0] || ext_in);
    end

    // Advance the phase and the bit pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= SAR_IDLE;
            ptr     <= '0;
        end else begin
            case (phase_q)
                SAR_IDLE, SAR_DONE: begin
                    if (load) begin
                        phase_q <= SAR_BUSY;
                        ptr     <= MSB_HOT;
                    end
                end
                SAR_BUSY: begin
                    if (last) begin
                        phase_q <= SAR_DONE;
                        ptr     <= '0;
                    end else begin
                        ptr <= ptr >> 1;
                    end
                end
                default: begin
                    phase_q <= SAR_IDLE;
                    ptr     <= '0;
                end
            endcase
        end
    end

    // R3: exactly one bit is under test during a conversion
    p_one_trial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(ptr) == 1));

    // R3: pointer steps one position down per edge
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && (ptr == ($past(ptr) >> 1))));

    // R4: the final decision edge leads to the finished phase
    p_end_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> done);

    // R6: a start request cannot cut a running conversion short
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last && start) |=> busy);

    // R4: finished phase holds while no start arrives
    p_done_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: rtl/sar_bit_slice.sv
// One bit of the approximation code: set as a trial bit, then resolved
// from the comparator on the edge where it is under test.
// Assumes: at most one of test_en and set_en is high in a cycle.
module sar_bit_slice #(
    parameter bit IS_MSB = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic test_en,
    input  logic set_en,
    input  logic cmp,
    output logic q
);

    // Hold, seed, resolve or set this code bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (load) begin
            q <= IS_MSB;
        end else if (test_en) begin
            q <= cmp;
        end else if (set_en) begin
            q <= 1'b1;
        end
    end

    // R3: the bit under test keeps the comparator answer
    p_bit_resolve_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !load) |=> (q == $past(cmp)));

    // R3: the next lower bit becomes the trial bit
    p_bit_trial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !load && !test_en) |=> q);

endmodule

// File: rtl/sar_serial_tap.sv
// Serial result stream: registers each decided bit as it is resolved.
// Assumes: shift_en is high exactly on decision edges.
module sar_serial_tap (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    output logic ser_out
);

    // Capture the decision of the current edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= 1'b0;
        end else if (shift_en) begin
            ser_out <= bit_in;
        end
    end

    // R5: serial output is frozen between conversions
    p_ser_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(ser_out));

endmodule

// File: rtl/sar_cascadable_reg.sv
// Cascadable successive approximation register (top).
// Drives a trial code to an external DAC, resolves it from a comparator
// bit MSB first, streams decisions serially and flags completion.
// Assumes: start pulses are shorter than one conversion when driven
// externally; ext_in is low or tied to a code bit.
module sar_cascadable_reg #(
    parameter int WIDTH    = 8,
    parameter bit FREE_RUN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_in,
    input  logic             ext_in,
    output logic [WIDTH-1:0] code_q,
    output logic             ser_out,
    output logic             eoc,
    output logic             carry_out
);

    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    logic             load;
    logic             busy;
    logic             last;
    logic             done;
    logic [WIDTH-1:0] ptr;

    sar_sequencer #(
        .WIDTH    (WIDTH),
        .FREE_RUN (FREE_RUN)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .ext_in (ext_in),
        .load   (load),
        .busy   (busy),
        .last   (last),
        .done   (done),
        .ptr    (ptr)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic test_en;
        logic set_en;

        assign test_en = busy && ptr[b];

        if (b == WIDTH - 1) begin : g_top
            assign set_en = 1'b0;
        end else begin : g_low
            assign set_en = busy && ptr[b+1] && !last;
        end

        sar_bit_slice #(
            .IS_MSB (b == WIDTH - 1)
        ) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .test_en (test_en),
            .set_en  (set_en),
            .cmp     (cmp_in),
            .q       (code_q[b])
        );
    end

    sar_serial_tap u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (busy),
        .bit_in   (cmp_in),
        .ser_out  (ser_out)
    );

    assign eoc       = done;
    assign carry_out = last;

    // R2: an accepted start seeds the MSB-only trial code
    p_seed_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((code_q == MSB_ONLY) && !eoc));

    // R4: the code holds outside a conversion
    p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> $stable(code_q));

    // R9: the carry is never raised outside a conversion
    p_carry_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> !eoc);

    // R5: the last serial bit coincides with the rising end flag
    p_ser_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |=> (eoc && (ser_out == $past(cmp_in))));

endmodule

// File: tb/test_sar_cascadable_reg.sv
module test_sar_cascadable_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_r = 1'b0;
    logic       fb = 1'b0;
    logic       ext_en = 1'b0;
    logic [2:0] ext_k = 3'd0;
    logic [7:0] vin = 8'd0;
    logic [7:0] q;
    logic       ser, eoc, cout, cmp, start_w, ext_w;

    logic [11:0] vin12 = 12'h9C3;
    logic [7:0]  hq, lq;
    logic        h_ser, h_eoc, h_cout, l_ser, l_eoc, l_cout, h_cmp, l_cmp;

    int nvec = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    assign start_w = fb ? eoc : start_r;
    assign ext_w   = ext_en && q[ext_k];
    assign cmp     = (q <= vin);
    assign h_cmp   = ({hq, 4'b0000} <= vin12);
    assign l_cmp   = ({hq, lq[7:4]} <= vin12);

    sar_cascadable_reg #(.WIDTH(8), .FREE_RUN(1'b0)) i_sar_cascadable_reg (
        .clk(clk), .rst_n(rst_n), .start(start_w), .cmp_in(cmp), .ext_in(ext_w),
        .code_q(q), .ser_out(ser), .eoc(eoc), .carry_out(cout));

    sar_cascadable_reg #(.WIDTH(8), .FREE_RUN(1'b1)) i_chain_hi (
        .clk(clk), .rst_n(rst_n), .start(l_eoc), .cmp_in(h_cmp), .ext_in(1'b0),
        .code_q(hq), .ser_out(h_ser), .eoc(h_eoc), .carry_out(h_cout));

    sar_cascadable_reg #(.WIDTH(8), .FREE_RUN(1'b0)) i_chain_lo (
        .clk(clk), .rst_n(rst_n), .start(h_cout), .cmp_in(l_cmp), .ext_in(lq[4]),
        .code_q(lq), .ser_out(l_ser), .eoc(l_eoc), .carry_out(l_cout));

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One externally started conversion, checked cycle by cycle.
    task automatic run_conv(input logic [7:0] v, input logic use_ext,
                            input logic [2:0] k, input logic poke);
        int n;
        logic [7:0] expv;
        n = use_ext ? 8 - int'(k) : 8;
        expv = use_ext ? ((v >> k) << k) : v;
        vin = v; ext_en = use_ext; ext_k = k; start_r = 1'b1;
        @(negedge clk);
        start_r = 1'b0;
        chk("R2 seed code", int'(q), 128);
        chk("R2 eoc low after load", int'(eoc), 0);
        for (int i = 0; i < n; i++) begin
            chk("R9 carry", int'(cout), (i == n - 1) ? 1 : 0);
            if (poke && i == 1) start_r = 1'b1;
            @(negedge clk);
            start_r = 1'b0;
            chk("R5 serial bit", int'(ser), int'(expv[7-i]));
            if (i < n - 1) chk("R4 eoc early", int'(eoc), 0);
        end
        chk(use_ext ? "R8 short code" : "R3 final code", int'(q), int'(expv));
        chk(poke ? "R6 eoc with start poke" : "R4 eoc at end", int'(eoc), 1);
        @(negedge clk);
        chk("R4 code holds", int'(q), int'(expv));
        chk("R4 eoc holds", int'(eoc), 1);
    endtask

    // Cycles from one rising eoc of the main register to the next.
    task automatic eoc_period(output int cnt);
        logic prev;
        cnt = 0;
        prev = eoc;
        while (cnt < 60) begin
            @(negedge clk);
            cnt++;
            if (eoc && !prev) break;
            prev = eoc;
        end
    endtask

    // Cycles from one rising eoc of the lower chain stage to the next.
    task automatic lo_period(output int cnt);
        logic prev;
        cnt = 0;
        prev = l_eoc;
        while (cnt < 80) begin
            @(negedge clk);
            cnt++;
            if (l_eoc && !prev) break;
            prev = l_eoc;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 upper stage self-start", int'(hq), 128);
        chk("R11 lower stage idle code", int'(lq), 0);
        chk("R11 lower stage idle eoc", int'(l_eoc), 0);
        for (int c = 0; c < 3; c++) begin
            chk("R1 code idle", int'(q), 0);
            chk("R1 eoc idle", int'(eoc), 0);
            chk("R1 serial idle", int'(ser), 0);
            chk("R1 carry idle", int'(cout), 0);
            @(negedge clk);
        end

        // R3 R5 R6: every level, full length
        for (int v = 0; v < 256; v++)
            run_conv(8'(v), 1'b0, 3'd0, (v % 7) == 3);

        // R8: shortened conversions for every tap
        for (int k = 0; k < 8; k++)
            for (int v = 0; v < 256; v += 17)
                run_conv(8'(v), 1'b1, 3'(k), 1'b0);
        for (int k = 0; k < 8; k++)
            run_conv(8'hFF, 1'b1, 3'(k), 1'b0);

        // R7: end flag fed back to start
        ext_en = 1'b0; vin = 8'hA5; fb = 1'b1;
        eoc_period(per);
        for (int r = 0; r < 3; r++) begin
            eoc_period(per);
            chk("R7 feedback period", per, 9);
            chk("R7 feedback code", int'(q), 8'hA5);
        end
        fb = 1'b0;

        // R7 R6: start held high
        vin = 8'h3C; start_r = 1'b1;
        eoc_period(per);
        for (int r = 0; r < 3; r++) begin
            eoc_period(per);
            chk("R7 held start period", per, 9);
            chk("R7 held start code", int'(q), 8'h3C);
        end
        start_r = 1'b0;
        eoc_period(per);

        // R11: chained 12-bit free-running converter
        lo_period(per);
        for (int j = 0; j < 20; j++) begin
            logic [11:0] lvl;
            lvl = (j == 0) ? 12'd0 : (j == 1) ? 12'hFFF : 12'((j * 1237 + 55) % 4096);
            vin12 = lvl;
            lo_period(per);
            chk("R11 chain period", per, 13);
            chk("R11 chain code", int'({hq, lq[7:4]}), int'(lvl));
            chk("R11 lower bits cleared", int'(lq[3:0]), 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule